// File: doc/BRIEF.md
# Video Processor CPU Port Interface

This block sits between a CPU and a tile-based video processor. The CPU sees two byte-wide ports: a data port and a control port, picked by one select bit and accessed with read and write strobes. A pair of control writes forms a command. The command sets a 14-bit video RAM address and a 2-bit access code. The code decides what the following data-port writes do: they go to video RAM, or they go to a 32-entry colour RAM. The same pair of writes can also load one of sixteen internal configuration registers.

Data-port reads are served from a one-byte read-ahead buffer. Each read returns the buffered byte, refills the buffer from video RAM and advances the address. Video RAM is a plain synchronous memory with one cycle of read latency. While a refill is in flight the block drops `cpu_ready_o`, and a CPU strobe seen while ready is low is ignored. A status read on the control port returns the status byte, then clears the status bits, both pending interrupt flags and the command half-written flag. The timing block supplies the status and interrupt events. It receives back the two interrupt enables held in the registers.

Top module: `vdp_cpu_port`

## Requirements
- R1: A control write made while no command is half-written loads address bits 7:0. The next control write loads address bits 13:8 from its bits 5:0 and the access code from its bits 7:6. Codes: 0 = prefetch read, 1 = video RAM write, 2 = register write, 3 = colour RAM write.
- R2: The half-written flag flips on every control write. A data read, a data write or a status read clears it, so the next control byte is taken as a first byte.
- R3: Completing a command with code 0 reads video RAM at the new address into the read buffer and leaves the address at the new address plus one.
- R4: Completing a command with code 2 writes the value of address bits 7:0 into the register numbered by bits 3:0 of the second byte. Register n appears on `regs_o[8n+7:8n]` and all registers reset to 0.
- R5: A data read returns the buffer contents on `cpu_rdata_o` in the cycle after it is accepted. It then refills the buffer from video RAM at the current address and increments the address modulo 2^14, so 0x3FFF wraps to 0x0000. `cpu_rdata_o` holds its value until the next accepted read.
- R6: A data write with code 3 issues one colour RAM write at address bits 4:0. With any other code it issues one video RAM write at the full address. Either way the address increments and the written byte becomes the new buffer contents.
- R7: A status read returns the frame-interrupt pending flag in bit 7 and the accumulated status bits in bits 6:0. It then clears the status bits, the line and frame pending flags and the half-written flag.
- R8: While register 0 bit 2 is set, a status read returns 1 in bits 4:0 whatever the stored status.
- R9: An access that starts a refill drives `vram_re_o` in the next cycle. `cpu_ready_o` is low in that cycle and the one after it, then returns high. A strobe presented while `cpu_ready_o` is low has no effect.
- R10: `line_irq_en_o` follows register 0 bit 4 and `frame_irq_en_o` follows register 1 bit 5.
- R11: `cpu_irq_o` is high when the line flag is pending with register 0 bit 4 set, or the frame flag is pending with register 1 bit 5 set. Event pulses set the flags and a status read clears them.
- R12: After reset the address, the code, the buffer, the status and the registers are zero, `cpu_ready_o` is high and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel_i | input | 1 | Port select: 0 data, 1 control |
| cpu_rd_i | input | 1 | Read strobe, one cycle per access |
| cpu_wr_i | input | 1 | Write strobe, one cycle per access; wins over a read |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, registered |
| cpu_ready_o | output | 1 | High when an access can be accepted |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| vram_addr_o | output | 14 | Video RAM address |
| vram_re_o | output | 1 | Video RAM read request, data one cycle later |
| vram_we_o | output | 1 | Video RAM write enable |
| vram_wdata_o | output | 8 | Video RAM write data |
| vram_rdata_i | input | 8 | Video RAM read data |
| cram_we_o | output | 1 | Colour RAM write enable |
| cram_addr_o | output | 5 | Colour RAM entry |
| cram_wdata_o | output | 8 | Colour RAM write data |
| stat_set_i | input | 7 | Status bits to set, from the timing block |
| line_evt_i | input | 1 | Line interrupt event pulse |
| frame_evt_i | input | 1 | Frame interrupt event pulse |
| line_irq_en_o | output | 1 | Line interrupt enable |
| frame_irq_en_o | output | 1 | Frame interrupt enable |
| regs_o | output | 128 | All sixteen registers, register n at bits 8n+7:8n |

## Verification
The bench targets five corner cases.

- A data access between the two control bytes. If the half-written flag were not cleared, the next byte would land in the high address and the code, and later writes would go to a wrong address.
- A data write followed by a data read. A design that did not let the write overwrite the buffer would return stale prefetched data instead of the written byte.
- Address wrap at 0x3FFF. A carry past bit 13 would be lost or misrouted.
- Status reads with the mode-4 bit set and clear. A missing clear would leave the interrupt asserted.
- A strobe issued during a refill stall. Accepting it would corrupt the address and the buffer.

Random command, data, status and event sequences run against a bench model of the port.

// File: rtl/vdp_port_pkg.sv
package vdp_port_pkg;

  // Access code carried in the top two bits of the second control byte
  typedef enum logic [1:0] {
    ACC_VRD  = 2'd0,
    ACC_VWR  = 2'd1,
    ACC_REG  = 2'd2,
    ACC_CRAM = 2'd3
  } acc_code_e;

  // Buffer refill sequencing around the one-cycle-latency memory
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_CAPT = 2'd2
  } fetch_ph_e;

endpackage

// File: rtl/vdp_regfile.sv
module vdp_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DW       = 8,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IW-1:0]          widx,
  input  logic [DW-1:0]          wdata,
  output logic [NUM_REGS*DW-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)                              r_q <= '0;
      else if (we && (widx == IW'(g)))      r_q <= wdata;
    end
    assign regs_flat[g*DW +: DW] = r_q;
  end

endmodule

// File: rtl/vdp_status.sv
module vdp_status #(
  parameter int DW        = 8,
  parameter int FILL_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [DW-2:0] stat_set,
  input  logic          line_evt,
  input  logic          frame_evt,
  input  logic          mode4,
  output logic [DW-1:0] status_byte,
  output logic          line_pend,
  output logic          frame_pend
);

  localparam logic [DW-1:0] FILL_MASK = DW'((1 << FILL_BITS) - 1);

  logic [DW-2:0] stat_q;

  // A new event in the clearing cycle survives the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q     <= '0;
      line_pend  <= 1'b0;
      frame_pend <= 1'b0;
    end else begin
      stat_q     <= (clr ? '0 : stat_q) | stat_set;
      line_pend  <= (line_pend  & ~clr) | line_evt;
      frame_pend <= (frame_pend & ~clr) | frame_evt;
    end
  end

  assign status_byte = {frame_pend, stat_q} | (mode4 ? FILL_MASK : '0);

endmodule

// File: rtl/vdp_cpu_port.sv
module vdp_cpu_port
  import vdp_port_pkg::*;
#(
  parameter int AW       = 14,
  parameter int DW       = 8,
  parameter int NUM_REGS = 16,
  parameter int CRAM_AW  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpu_sel_i,
  input  logic                   cpu_rd_i,
  input  logic                   cpu_wr_i,
  input  logic [DW-1:0]          cpu_wdata_i,
  output logic [DW-1:0]          cpu_rdata_o,
  output logic                   cpu_ready_o,
  output logic                   cpu_irq_o,
  output logic [AW-1:0]          vram_addr_o,
  output logic                   vram_re_o,
  output logic                   vram_we_o,
  output logic [DW-1:0]          vram_wdata_o,
  input  logic [DW-1:0]          vram_rdata_i,
  output logic                   cram_we_o,
  output logic [CRAM_AW-1:0]     cram_addr_o,
  output logic [DW-1:0]          cram_wdata_o,
  input  logic [DW-2:0]          stat_set_i,
  input  logic                   line_evt_i,
  input  logic                   frame_evt_i,
  output logic                   line_irq_en_o,
  output logic                   frame_irq_en_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);

  localparam int IW           = $clog2(NUM_REGS);
  localparam int HW           = AW - DW;
  localparam int MODE4_BIT    = 2;
  localparam int LINE_EN_BIT  = 4;
  localparam int FRAME_EN_BIT = DW + 5;

  fetch_ph_e     ph_q;
  acc_code_e     code_q, new_code;
  logic [AW-1:0] addr_q, new_addr, fetch_addr;
  logic [DW-1:0] buf_q, status_byte;
  logic          pend_q, line_pend, frame_pend;
  logic          accept, dat_rd, dat_wr, ctl_rd, ctl_wr, fetch, rf_we;
  logic [NUM_REGS*DW-1:0] regs_w;

  always_comb begin
    accept     = (ph_q == PH_IDLE) && (cpu_rd_i || cpu_wr_i);
    dat_wr     = accept &&  cpu_wr_i && !cpu_sel_i;
    ctl_wr     = accept &&  cpu_wr_i &&  cpu_sel_i;
    dat_rd     = accept && !cpu_wr_i && !cpu_sel_i;
    ctl_rd     = accept && !cpu_wr_i &&  cpu_sel_i;
    new_code   = acc_code_e'(cpu_wdata_i[DW-1 -: 2]);
    new_addr   = {cpu_wdata_i[HW-1:0], addr_q[DW-1:0]};
    rf_we      = ctl_wr && pend_q && (new_code == ACC_REG);
    fetch      = dat_rd || (ctl_wr && pend_q && (new_code == ACC_VRD));
    fetch_addr = dat_rd ? addr_q : new_addr;
  end

  vdp_regfile #(.NUM_REGS(NUM_REGS), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (rf_we),
    .widx      (cpu_wdata_i[IW-1:0]),
    .wdata     (addr_q[DW-1:0]),
    .regs_flat (regs_w)
  );

  vdp_status #(.DW(DW), .FILL_BITS(5)) u_status (
    .clk         (clk),
    .rst         (rst),
    .clr         (ctl_rd),
    .stat_set    (stat_set_i),
    .line_evt    (line_evt_i),
    .frame_evt   (frame_evt_i),
    .mode4       (regs_w[MODE4_BIT]),
    .status_byte (status_byte),
    .line_pend   (line_pend),
    .frame_pend  (frame_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q         <= PH_IDLE;
      code_q       <= ACC_VRD;
      addr_q       <= '0;
      buf_q        <= '0;
      pend_q       <= 1'b0;
      cpu_rdata_o  <= '0;
      vram_addr_o  <= '0;
      vram_re_o    <= 1'b0;
      vram_we_o    <= 1'b0;
      vram_wdata_o <= '0;
      cram_we_o    <= 1'b0;
      cram_addr_o  <= '0;
      cram_wdata_o <= '0;
    end else begin
      vram_re_o <= 1'b0;
      vram_we_o <= 1'b0;
      cram_we_o <= 1'b0;

      unique case (ph_q)
        PH_REQ:  ph_q <= PH_CAPT;
        PH_CAPT: begin
          buf_q <= vram_rdata_i;
          ph_q  <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase

      if (ctl_wr) begin
        pend_q <= ~pend_q;
        if (!pend_q) begin
          addr_q[DW-1:0] <= cpu_wdata_i;
        end else begin
          addr_q <= new_addr;
          code_q <= new_code;
        end
      end

      if (dat_wr) begin
        pend_q <= 1'b0;
        buf_q  <= cpu_wdata_i;
        addr_q <= addr_q + AW'(1);
        if (code_q == ACC_CRAM) begin
          cram_we_o    <= 1'b1;
          cram_addr_o  <= addr_q[CRAM_AW-1:0];
          cram_wdata_o <= cpu_wdata_i;
        end else begin
          vram_we_o    <= 1'b1;
          vram_addr_o  <= addr_q;
          vram_wdata_o <= cpu_wdata_i;
        end
      end

      if (dat_rd) begin
        pend_q      <= 1'b0;
        cpu_rdata_o <= buf_q;
      end

      if (ctl_rd) begin
        pend_q      <= 1'b0;
        cpu_rdata_o <= status_byte;
      end

      if (fetch) begin
        ph_q        <= PH_REQ;
        vram_re_o   <= 1'b1;
        vram_addr_o <= fetch_addr;
        addr_q      <= fetch_addr + AW'(1);
      end
    end
  end

  assign cpu_ready_o    = (ph_q == PH_IDLE);
  assign line_irq_en_o  = regs_w[LINE_EN_BIT];
  assign frame_irq_en_o = regs_w[FRAME_EN_BIT];
  assign cpu_irq_o      = (line_pend & regs_w[LINE_EN_BIT]) |
                          (frame_pend & regs_w[FRAME_EN_BIT]);
  assign regs_o         = regs_w;

endmodule

// File: rtl/vdp_cpu_port_chk.sv
module vdp_cpu_port_chk (
  input logic clk,
  input logic rst,
  input logic cpu_sel_i,
  input logic cpu_rd_i,
  input logic cpu_wr_i,
  input logic [7:0] cpu_rdata_o,
  input logic cpu_ready_o,
  input logic cpu_irq_o,
  input logic vram_re_o,
  input logic vram_we_o,
  input logic cram_we_o,
  input logic line_evt_i,
  input logic frame_evt_i
);

  AST_FETCH_STALL: assert property (@(posedge clk) disable iff (rst)
    vram_re_o |-> !cpu_ready_o); // R9

  AST_FETCH_RESUME: assert property (@(posedge clk) disable iff (rst)
    vram_re_o |=> !cpu_ready_o ##1 cpu_ready_o); // R9

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!cpu_ready_o && cpu_wr_i) |=> (!vram_we_o && !cram_we_o)); // R9

  AST_ONE_WRITE_ISSUED: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready_o && cpu_wr_i && !cpu_sel_i) |=> (vram_we_o != cram_we_o)); // R6

  AST_READ_REFILLS: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready_o && cpu_rd_i && !cpu_wr_i && !cpu_sel_i) |=> vram_re_o); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ready_o && cpu_rd_i && !cpu_wr_i) |=> $stable(cpu_rdata_o)); // R5

  AST_STATUS_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready_o && cpu_rd_i && !cpu_wr_i && cpu_sel_i && !line_evt_i && !frame_evt_i)
      |=> !cpu_irq_o); // R7

endmodule

bind vdp_cpu_port vdp_cpu_port_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .cpu_sel_i   (cpu_sel_i),
  .cpu_rd_i    (cpu_rd_i),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_rdata_o (cpu_rdata_o),
  .cpu_ready_o (cpu_ready_o),
  .cpu_irq_o   (cpu_irq_o),
  .vram_re_o   (vram_re_o),
  .vram_we_o   (vram_we_o),
  .cram_we_o   (cram_we_o),
  .line_evt_i  (line_evt_i),
  .frame_evt_i (frame_evt_i)
);

// File: tb/vdp_cpu_port_tb_top.sv
module vdp_cpu_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 1024;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_sel_i = 1'b0, cpu_rd_i = 1'b0, cpu_wr_i = 1'b0;
  logic [7:0]   cpu_wdata_i = '0;
  logic [7:0]   cpu_rdata_o;
  logic         cpu_ready_o, cpu_irq_o;
  logic [13:0]  vram_addr_o;
  logic         vram_re_o, vram_we_o;
  logic [7:0]   vram_wdata_o;
  logic [7:0]   vram_rdata_i = '0;
  logic         cram_we_o;
  logic [4:0]   cram_addr_o;
  logic [7:0]   cram_wdata_o;
  logic [6:0]   stat_set_i = '0;
  logic         line_evt_i = 1'b0, frame_evt_i = 1'b0;
  logic         line_irq_en_o, frame_irq_en_o;
  logic [127:0] regs_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdp_cpu_port dut_i (
    .clk(clk), .rst(rst), .cpu_sel_i(cpu_sel_i), .cpu_rd_i(cpu_rd_i),
    .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .cpu_ready_o(cpu_ready_o), .cpu_irq_o(cpu_irq_o), .vram_addr_o(vram_addr_o),
    .vram_re_o(vram_re_o), .vram_we_o(vram_we_o), .vram_wdata_o(vram_wdata_o),
    .vram_rdata_i(vram_rdata_i), .cram_we_o(cram_we_o), .cram_addr_o(cram_addr_o),
    .cram_wdata_o(cram_wdata_o), .stat_set_i(stat_set_i), .line_evt_i(line_evt_i),
    .frame_evt_i(frame_evt_i), .line_irq_en_o(line_irq_en_o),
    .frame_irq_en_o(frame_irq_en_o), .regs_o(regs_o)
  );

  // Environment memory with one cycle of read latency (low address bits only)
  logic [7:0] mem [MEM_N];
  always @(posedge clk) begin
    if (vram_we_o) mem[vram_addr_o[9:0]] <= vram_wdata_o;
    if (vram_re_o) vram_rdata_i <= mem[vram_addr_o[9:0]];
  end

  // Bench model
  logic [7:0]  mm [MEM_N];
  logic [13:0] m_addr;
  logic [1:0]  m_code;
  logic        m_pend, m_lp, m_fp;
  logic [7:0]  m_buf;
  logic [7:0]  m_regs [16];
  logic [6:0]  m_stat;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_fp, m_stat} | (m_regs[0][2] ? 8'h1f : 8'h00);
  endfunction

  function automatic logic exp_irq();
    return (m_lp & m_regs[0][4]) | (m_fp & m_regs[1][5]);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  // One accepted access; returns at the negedge after the accepting edge
  task automatic acc(input logic sel, input logic wr, input logic [7:0] d);
    while (!cpu_ready_o) @(negedge clk);
    cpu_sel_i = sel; cpu_wr_i = wr; cpu_rd_i = !wr; cpu_wdata_i = d;
    @(negedge clk);
    cpu_wr_i = 1'b0; cpu_rd_i = 1'b0;
  endtask

  task automatic wait_refill();
    chk("R9 ready low cycle 1", cpu_ready_o, 0);
    chk("R9 read request", vram_re_o, 1);
    @(negedge clk);
    chk("R9 ready low cycle 2", cpu_ready_o, 0);
    @(negedge clk);
    chk("R9 ready back", cpu_ready_o, 1);
  endtask

  task automatic ctl_write(input logic [7:0] d);
    logic [13:0] na;
    acc(1'b1, 1'b1, d);
    if (!m_pend) begin
      m_addr[7:0] = d;
      m_pend = 1'b1;
    end else begin
      na = {d[5:0], m_addr[7:0]};
      m_code = d[7:6];
      m_pend = 1'b0;
      m_addr = na;
      if (d[7:6] == 2'd2) begin
        m_regs[d[3:0]] = na[7:0];
        chk("R4 register value", regs_o[d[3:0]*8 +: 8], na[7:0]);
        chk("R10 line enable", line_irq_en_o, m_regs[0][4]);
        chk("R10 frame enable", frame_irq_en_o, m_regs[1][5]);
      end
      if (d[7:6] == 2'd0) begin
        chk("R3 prefetch address", vram_addr_o, na);
        wait_refill();
        m_buf = mm[na[9:0]];
        m_addr = na + 14'd1;
      end
    end
  endtask

  task automatic dat_write(input logic [7:0] d);
    acc(1'b0, 1'b1, d);
    if (m_code == 2'd3) begin
      chk("R6 cram we", cram_we_o, 1);
      chk("R6 cram addr", cram_addr_o, m_addr[4:0]);
      chk("R6 cram data", cram_wdata_o, d);
      chk("R6 no vram we", vram_we_o, 0);
    end else begin
      chk("R6 vram we", vram_we_o, 1);
      chk("R1 R6 vram addr", vram_addr_o, m_addr);
      chk("R6 vram data", vram_wdata_o, d);
      chk("R6 no cram we", cram_we_o, 0);
      mm[m_addr[9:0]] = d;
    end
    m_buf = d;
    m_addr = m_addr + 14'd1;
    m_pend = 1'b0;
  endtask

  task automatic dat_read();
    acc(1'b0, 1'b0, 8'h00);
    chk("R5 read returns buffer", cpu_rdata_o, m_buf);
    chk("R5 refill address", vram_addr_o, m_addr);
    wait_refill();
    m_buf = mm[m_addr[9:0]];
    m_addr = m_addr + 14'd1;
    m_pend = 1'b0;
  endtask

  task automatic stat_read();
    acc(1'b1, 1'b0, 8'h00);
    chk("R7 R8 status byte", cpu_rdata_o, exp_status());
    m_stat = '0; m_lp = 1'b0; m_fp = 1'b0; m_pend = 1'b0;
    chk("R7 R11 irq cleared", cpu_irq_o, 0);
  endtask

  task automatic events(input logic [6:0] s, input logic l, input logic f);
    stat_set_i = s; line_evt_i = l; frame_evt_i = f;
    @(negedge clk);
    stat_set_i = '0; line_evt_i = 1'b0; frame_evt_i = 1'b0;
    m_stat = m_stat | s; m_lp = m_lp | l; m_fp = m_fp | f;
    chk("R11 irq level", cpu_irq_o, exp_irq());
  endtask

  task automatic set_cmd(input logic [13:0] a, input logic [1:0] c);
    ctl_write(a[7:0]);
    ctl_write({c, a[13:8]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = init_val(i);
      mm[i]  = init_val(i);
    end
    for (int i = 0; i < 16; i++) m_regs[i] = '0;
    m_addr = '0; m_code = '0; m_pend = 0; m_buf = '0; m_stat = '0; m_lp = 0; m_fp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 ready", cpu_ready_o, 1);
    chk("R12 regs", regs_o, 128'd0);
    chk("R12 irq", cpu_irq_o, 0);
    chk("R12 no writes", {vram_we_o, cram_we_o, vram_re_o}, 3'b000);
    chk("R12 rdata", cpu_rdata_o, 0);

    // R1 pair assembly, code 1 write
    set_cmd(14'h1234, 2'd1);
    dat_write(8'h5a);
    dat_write(8'h5b);

    // R2 half-written flag cleared by a data read between bytes
    ctl_write(8'h40);
    dat_read();
    set_cmd(14'h0210, 2'd1);
    dat_write(8'hc3);

    // R2 cleared by a status read too
    ctl_write(8'h77);
    stat_read();
    set_cmd(14'h0300, 2'd1);
    dat_write(8'h11);

    // R3 prefetch then read back; R6 write replaces buffer
    set_cmd(14'h0210, 2'd0);
    dat_read();
    dat_write(8'h99);
    dat_read();

    // R5 wrap at the top of the address space
    set_cmd(14'h3fff, 2'd1);
    dat_write(8'h42);
    chk("R5 wrapped address", m_addr, 14'h0000);
    dat_write(8'h43);

    // R6 colour RAM writes
    set_cmd(14'h003e, 2'd3);
    dat_write(8'h0f);
    dat_write(8'h30);

    // R4 register writes, R10 enables, R8 fill bits, R11 irq
    set_cmd(14'h0014, 2'd2);
    set_cmd(14'h0020, 2'd2);
    {m_code} = 2'd2;
    events(7'h40, 1'b1, 1'b1);
    stat_read();
    set_cmd(14'h0004, 2'd2);
    events(7'h20, 1'b0, 1'b1);
    stat_read();
    stat_read();

    // R9 strobe during a refill is ignored
    set_cmd(14'h0100, 2'd1);
    acc(1'b0, 1'b0, 8'h00);
    chk("R5 read data", cpu_rdata_o, m_buf);
    m_buf = mm[m_addr[9:0]];
    m_addr = m_addr + 14'd1;
    m_pend = 1'b0;
    cpu_sel_i = 1'b0; cpu_wr_i = 1'b1; cpu_wdata_i = 8'haa;
    @(negedge clk);
    cpu_wr_i = 1'b0;
    chk("R9 busy write ignored", {vram_we_o, cram_we_o}, 2'b00);
    while (!cpu_ready_o) @(negedge clk);
    dat_write(8'h5c);
    dat_read();

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: ctl_write(8'($urandom));
        3, 4:    dat_write(8'($urandom));
        5, 6:    dat_read();
        7:       stat_read();
        default: events(7'($urandom), 1'($urandom), 1'($urandom));
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule